// File: doc/BRIEF.md
# Dual-Stream Packet Sideband Splitter

This block sits on the transmit side of a descriptor-driven stream DMA engine. Each descriptor names one fragment of a packet. It carries start and end markers, a control word whose low bits give the fragment length, and a five-word sideband record. The fragment bytes follow on a byte-wide input. The block turns this into two AXI4-Stream outputs. A 32-bit control stream carries the five-word sideband record of each packet. A byte-wide data stream carries the packet itself. The control record always goes out before any data byte of its packet, and each output honours its own backpressure.

Fragments are gathered in a local frame buffer. The whole frame is released on the data stream only once the fragment marked as the end of the packet has been taken in. A start-marked descriptor that arrives while a frame is still open throws the partial frame away and pulses an error output.

A small receive-side companion watches an incoming control stream and an incoming data stream. It keeps the last well-formed five-word record. When an incoming data frame ends, it releases that record together with an end-of-frame status flag.

The transmit state machine has four states:
- IDLE waits for a descriptor.
- CTRL sends the five control words.
- FILL takes in the fragment bytes.
- DATA replays the frame.

Its transitions are:
- IDLE to CTRL on a start-marked descriptor.
- IDLE to FILL on any other descriptor.
- CTRL to FILL after the fifth word is accepted.
- FILL to IDLE when the fragment is complete and either the fragment is not end-marked or the frame holds no bytes.
- FILL to DATA when an end-marked fragment completes with bytes buffered.
- DATA to IDLE after the last byte is accepted.

Top module: `sideband_splitter`

## Requirements
- R1: After reset, `desc_ready` is 1 and `ctl_tvalid`, `dat_tvalid`, `tx_err`, `cmp_valid`, `cmp_eof` and `rx_err` are 0.
- R2: A start-marked descriptor produces exactly five control beats. Beat k carries `desc_side[32k+31:32k]` unchanged, word 0 first. Because the word is unchanged, stream bits 7:0 hold the least significant byte. `ctl_tlast` is 1 on the fifth beat only.
- R3: The fragment length is `desc_ctrl[LEN_BITS-1:0]` (LEN_BITS defaults to 16), and the upper control bits are ignored. Exactly that many bytes are accepted, after which `frag_ready` drops.
- R4: Bytes of successive fragments are concatenated in arrival order. No data beat appears until the end-marked fragment is complete. The frame then comes out in order, with `dat_tlast` on its last byte only.
- R5: `dat_tvalid` is never 1 while a control record is being sent. Each packet's control record completes before its first data beat.
- R6: While a valid output beat is not accepted, its valid stays 1 and its payload stays unchanged. No beat is lost or repeated.
- R7: A start-marked descriptor arriving while a frame is open discards the buffered bytes. It pulses `tx_err` for one cycle, and the new frame starts empty.
- R8: A descriptor without the start marker emits no control beats.
- R9: A zero-length end-marked descriptor closes the frame and releases the bytes buffered so far. A frame with no bytes produces no data beats.
- R10: An incoming control record of five beats ending with tlast becomes the held record. When an incoming data beat with tlast is seen, `cmp_valid` pulses in the following cycle. At that point `cmp_rec` carries the held record (word 0 in bits 31:0) and `cmp_eof` is 1. `cmp_eof` returns to 0 on the next data beat without tlast.
- R11: An incoming control record whose tlast comes on any beat other than the fifth pulses `rx_err` for one cycle and leaves the held record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_sof | input | 1 | Fragment starts a packet |
| desc_eof | input | 1 | Fragment ends a packet |
| desc_ctrl | input | 32 | Control word, fragment length in the low bits |
| desc_side | input | 160 | Five sideband words, word 0 in bits 31:0 |
| frag_valid | input | 1 | Fragment byte offered |
| frag_ready | output | 1 | Fragment byte accepted |
| frag_byte | input | 8 | Fragment byte |
| ctl_tvalid | output | 1 | Control stream valid |
| ctl_tready | input | 1 | Control stream ready |
| ctl_tdata | output | 32 | Control stream word |
| ctl_tlast | output | 1 | Last word of record |
| dat_tvalid | output | 1 | Data stream valid |
| dat_tready | input | 1 | Data stream ready |
| dat_tdata | output | 8 | Data stream byte |
| dat_tlast | output | 1 | Last byte of frame |
| tx_err | output | 1 | Open frame aborted |
| rxc_tvalid | input | 1 | Incoming control valid |
| rxc_tready | output | 1 | Incoming control ready (always 1) |
| rxc_tdata | input | 32 | Incoming control word |
| rxc_tlast | input | 1 | Incoming control last |
| rxd_tvalid | input | 1 | Incoming data valid |
| rxd_tready | output | 1 | Incoming data ready (always 1) |
| rxd_tlast | input | 1 | Incoming data last |
| cmp_valid | output | 1 | Completion pulse |
| cmp_rec | output | 160 | Released control record |
| cmp_eof | output | 1 | End-of-frame status |
| rx_err | output | 1 | Bad control record length |

## Verification
The bench drives packets split across several fragments, with upper bits of the control word set, zero-length middle and closing fragments, and random stalls on both outputs. It watches for three failures. A design that ignored the length mask would take far more bytes. One that emitted per fragment would leak data before the closing fragment. One that replayed stale buffer contents after an abort would send the wrong bytes or the wrong count. On the receive side, short and long control records must leave the older record in place. A design that latched every record would release the wrong words at the next frame end, and a sticky status flag would show up as `cmp_eof` failing to clear on the next frame.

// File: rtl/sdsplit_pkg.sv
package sdsplit_pkg;
    localparam int CTL_WORDS = 5;
    localparam int WORD_W    = 32;
    localparam int SIDE_W    = CTL_WORDS * WORD_W;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CTRL,
        S_FILL,
        S_DATA
    } tx_state_e;
endpackage

// File: rtl/sdsplit_frame_buf.sv
module sdsplit_frame_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sdsplit_tx_fsm.sv
module sdsplit_tx_fsm
    import sdsplit_pkg::*;
#(
    parameter int LEN_BITS  = 16,
    parameter int BUF_DEPTH = 64,
    localparam int AW = $clog2(BUF_DEPTH),
    localparam int PW = $clog2(BUF_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic              desc_sof,
    input  logic              desc_eof,
    input  logic [LEN_BITS-1:0] desc_len,
    input  logic [SIDE_W-1:0] desc_side,
    input  logic              frag_valid,
    output logic              frag_ready,
    output logic              ctl_tvalid,
    input  logic              ctl_tready,
    output logic [WORD_W-1:0] ctl_tdata,
    output logic              ctl_tlast,
    output logic              dat_tvalid,
    input  logic              dat_tready,
    output logic              dat_tlast,
    output logic              tx_err,
    output logic              buf_we,
    output logic [AW-1:0]     buf_waddr,
    output logic [AW-1:0]     buf_raddr
);
    tx_state_e           state, nxt;
    logic [SIDE_W-1:0]   side_q;
    logic [2:0]          widx;
    logic [LEN_BITS-1:0] remain;
    logic                eof_q, open_q, err_q;
    logic [PW-1:0]       pos, rdp;
    logic                last_word, last_byte, fill_done;

    assign last_word = (widx == 3'(CTL_WORDS - 1));
    assign last_byte = (rdp == pos - PW'(1));
    assign fill_done = (remain == '0);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (desc_valid) nxt = desc_sof ? S_CTRL : S_FILL;
            S_CTRL: if (ctl_tready && last_word) nxt = S_FILL;
            S_FILL: if (fill_done) nxt = (eof_q && pos != '0) ? S_DATA : S_IDLE;
            S_DATA: if (dat_tready && last_byte) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        desc_ready = (state == S_IDLE);
        ctl_tvalid = (state == S_CTRL);
        ctl_tlast  = (state == S_CTRL) && last_word;
        ctl_tdata  = side_q[int'(widx) * WORD_W +: WORD_W];
        frag_ready = (state == S_FILL) && !fill_done;
        dat_tvalid = (state == S_DATA);
        dat_tlast  = (state == S_DATA) && last_byte;
        buf_we     = frag_ready && frag_valid && (pos < PW'(BUF_DEPTH));
        buf_waddr  = pos[AW-1:0];
        buf_raddr  = rdp[AW-1:0];
        tx_err     = err_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= '0; widx <= '0; remain <= '0; eof_q <= 1'b0;
            open_q <= 1'b0; err_q <= 1'b0; pos <= '0; rdp <= '0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                S_IDLE: if (desc_valid) begin
                    remain <= desc_len;
                    eof_q  <= desc_eof;
                    open_q <= 1'b1;
                    rdp    <= '0;
                    if (desc_sof) begin
                        side_q <= desc_side;
                        widx   <= '0;
                        pos    <= '0;
                        err_q  <= open_q;
                    end
                end
                S_CTRL: if (ctl_tready) widx <= widx + 3'd1;
                S_FILL: begin
                    if (frag_valid && !fill_done) begin
                        remain <= remain - LEN_BITS'(1);
                        if (pos < PW'(BUF_DEPTH)) pos <= pos + PW'(1);
                    end
                    if (fill_done && eof_q) begin
                        open_q <= 1'b0;
                        if (pos == '0) pos <= '0;
                    end
                end
                S_DATA: if (dat_tready) begin
                    rdp <= rdp + PW'(1);
                    if (last_byte) pos <= '0;
                end
                default: ;
            endcase
        end
    end

    // independent beat counter used only by the checks below
    logic [2:0] chk_beats;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_beats <= '0;
        else if (ctl_tvalid && ctl_tready) chk_beats <= ctl_tlast ? 3'd0 : chk_beats + 3'd1;
    end

    AST_CTL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tvalid && ctl_tready && ctl_tlast) |-> (chk_beats == 3'd4)); // R2
    AST_CTL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_tvalid && dat_tvalid)); // R5
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tvalid && !ctl_tready) |=> (ctl_tvalid && $stable(ctl_tdata))); // R6
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_tvalid && !dat_tready) |=> (dat_tvalid && $stable(dat_tlast))); // R6
    AST_ABORT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(desc_valid && desc_ready && desc_sof)); // R7
endmodule

// File: rtl/sdsplit_rx_meta.sv
module sdsplit_rx_meta
    import sdsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxc_tvalid,
    input  logic [WORD_W-1:0] rxc_tdata,
    input  logic              rxc_tlast,
    input  logic              rxd_tvalid,
    input  logic              rxd_tlast,
    output logic              cmp_valid,
    output logic [SIDE_W-1:0] cmp_rec,
    output logic              cmp_eof,
    output logic              rx_err
);
    localparam int CAP_W = (CTL_WORDS - 1) * WORD_W;

    logic [CAP_W-1:0]  cap;
    logic [2:0]        cnt;
    logic [SIDE_W-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0; cnt <= '0; held <= '0; rx_err <= 1'b0;
            cmp_valid <= 1'b0; cmp_rec <= '0; cmp_eof <= 1'b0;
        end else begin
            rx_err    <= 1'b0;
            cmp_valid <= 1'b0;
            if (rxc_tvalid) begin
                if (rxc_tlast) begin
                    cnt <= '0;
                    if (cnt == 3'(CTL_WORDS - 1)) held <= {rxc_tdata, cap};
                    else                          rx_err <= 1'b1;
                end else begin
                    if (cnt < 3'(CTL_WORDS - 1)) cap[int'(cnt) * WORD_W +: WORD_W] <= rxc_tdata;
                    if (cnt != 3'(CTL_WORDS)) cnt <= cnt + 3'd1;
                end
            end
            if (rxd_tvalid) begin
                if (rxd_tlast) begin
                    cmp_valid <= 1'b1;
                    cmp_rec   <= held;
                    cmp_eof   <= 1'b1;
                end else begin
                    cmp_eof   <= 1'b0;
                end
            end
        end
    end

    AST_RX_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> $past(rxc_tvalid && rxc_tlast)); // R11
    AST_CMP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> ($past(rxd_tvalid && rxd_tlast) && cmp_eof)); // R10
endmodule

// File: rtl/sideband_splitter.sv
module sideband_splitter
    import sdsplit_pkg::*;
#(
    parameter int LEN_BITS  = 16,
    parameter int BUF_DEPTH = 64,
    localparam int AW = $clog2(BUF_DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         desc_valid,
    output logic         desc_ready,
    input  logic         desc_sof,
    input  logic         desc_eof,
    input  logic [31:0]  desc_ctrl,
    input  logic [159:0] desc_side,
    input  logic         frag_valid,
    output logic         frag_ready,
    input  logic [7:0]   frag_byte,
    output logic         ctl_tvalid,
    input  logic         ctl_tready,
    output logic [31:0]  ctl_tdata,
    output logic         ctl_tlast,
    output logic         dat_tvalid,
    input  logic         dat_tready,
    output logic [7:0]   dat_tdata,
    output logic         dat_tlast,
    output logic         tx_err,
    input  logic         rxc_tvalid,
    output logic         rxc_tready,
    input  logic [31:0]  rxc_tdata,
    input  logic         rxc_tlast,
    input  logic         rxd_tvalid,
    output logic         rxd_tready,
    input  logic         rxd_tlast,
    output logic         cmp_valid,
    output logic [159:0] cmp_rec,
    output logic         cmp_eof,
    output logic         rx_err
);
    logic          buf_we;
    logic [AW-1:0] buf_waddr, buf_raddr;
    logic          unused_ctrl_hi;

    assign unused_ctrl_hi = ^desc_ctrl[31:LEN_BITS];
    assign rxc_tready = 1'b1;
    assign rxd_tready = 1'b1;

    sdsplit_tx_fsm #(.LEN_BITS(LEN_BITS), .BUF_DEPTH(BUF_DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_sof(desc_sof), .desc_eof(desc_eof),
        .desc_len(desc_ctrl[LEN_BITS-1:0]), .desc_side(desc_side),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .ctl_tvalid(ctl_tvalid), .ctl_tready(ctl_tready),
        .ctl_tdata(ctl_tdata), .ctl_tlast(ctl_tlast),
        .dat_tvalid(dat_tvalid), .dat_tready(dat_tready), .dat_tlast(dat_tlast),
        .tx_err(tx_err),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_raddr(buf_raddr)
    );

    sdsplit_frame_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(frag_byte),
        .raddr(buf_raddr), .rdata(dat_tdata)
    );

    sdsplit_rx_meta u_rx (
        .clk(clk), .rst_n(rst_n),
        .rxc_tvalid(rxc_tvalid), .rxc_tdata(rxc_tdata), .rxc_tlast(rxc_tlast),
        .rxd_tvalid(rxd_tvalid), .rxd_tlast(rxd_tlast),
        .cmp_valid(cmp_valid), .cmp_rec(cmp_rec), .cmp_eof(cmp_eof), .rx_err(rx_err)
    );
endmodule

// File: tb/sideband_splitter_bench.sv
`timescale 1ns/1ps
module sideband_splitter_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic desc_valid = 0, desc_sof = 0, desc_eof = 0;
    logic [31:0] desc_ctrl = '0;
    logic [159:0] desc_side = '0;
    logic frag_valid = 0;
    logic [7:0] frag_byte = '0;
    logic ctl_tready = 1, dat_tready = 1;
    logic rxc_tvalid = 0, rxc_tlast = 0, rxd_tvalid = 0, rxd_tlast = 0;
    logic [31:0] rxc_tdata = '0;
    logic desc_ready, frag_ready, ctl_tvalid, ctl_tlast, dat_tvalid, dat_tlast, tx_err;
    logic [31:0] ctl_tdata;
    logic [7:0] dat_tdata;
    logic rxc_tready, rxd_tready, cmp_valid, cmp_eof, rx_err;
    logic [159:0] cmp_rec;

    always #2.5 clk = ~clk;

    sideband_splitter u_sideband_splitter (.*);

    int checks = 0, errors = 0, seen_err = 0, exp_err = 0, cyc = 0;
    logic [32:0] ctl_q[$];
    logic [8:0]  dat_q[$];
    logic [7:0]  acc[$];
    bit tb_open = 0, bp_en = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit pc_v = 0, pd_v = 0;
    logic [31:0] pc_d;
    logic [8:0] pd_d;

    task automatic chk(bit ok, string req, logic [159:0] act, logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            ctl_tready = 1; dat_tready = 1; pc_v = 0; pd_v = 0;
        end else begin
            if (pc_v) chk(ctl_tvalid && ctl_tdata == pc_d, "R6 ctl hold", ctl_tdata, pc_d);
            if (pd_v) chk(dat_tvalid && {dat_tlast, dat_tdata} == pd_d, "R6 dat hold",
                          {dat_tlast, dat_tdata}, pd_d);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ctl_tready = bp_en ? lfsr[0] : 1'b1;
            dat_tready = bp_en ? lfsr[5] : 1'b1;
            if (ctl_tvalid && ctl_tready) begin
                if (ctl_q.size() == 0) chk(0, "R8 unexpected control beat", ctl_tdata, 0);
                else begin
                    logic [32:0] e;
                    e = ctl_q.pop_front();
                    chk({ctl_tlast, ctl_tdata} == e, "R2 control beat", {ctl_tlast, ctl_tdata}, e);
                end
            end
            if (dat_tvalid && dat_tready) begin
                chk(ctl_q.size() == 0, "R5 data before control done", ctl_q.size(), 0);
                if (dat_q.size() == 0) chk(0, "R4 unexpected data beat", dat_tdata, 0);
                else begin
                    logic [8:0] e;
                    e = dat_q.pop_front();
                    chk({dat_tlast, dat_tdata} == e, "R4 data beat", {dat_tlast, dat_tdata}, e);
                end
            end
            pc_v = ctl_tvalid && !ctl_tready; pc_d = ctl_tdata;
            pd_v = dat_tvalid && !dat_tready; pd_d = {dat_tlast, dat_tdata};
            if (tx_err) seen_err++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired, run hung");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [159:0] mkside(logic [31:0] b);
        logic [159:0] r;
        for (int k = 0; k < 5; k++) r[32*k +: 32] = b + 32'(k * 16'h0101);
        return r;
    endfunction

    task automatic send(bit sof, bit eof, int len, logic [31:0] sb, logic [7:0] base);
        logic [159:0] side;
        side = mkside(sb);
        @(negedge clk);
        desc_valid = 1; desc_sof = sof; desc_eof = eof; desc_side = side;
        desc_ctrl = {16'hA5C3, 16'(len)}; // R3: upper bits are junk
        while (!desc_ready) @(negedge clk);
        if (sof) begin
            if (tb_open) exp_err++;
            acc.delete();
            for (int k = 0; k < 5; k++) ctl_q.push_back({k == 4, side[32*k +: 32]});
        end
        tb_open = 1;
        @(negedge clk);
        desc_valid = 0;
        for (int i = 0; i < len; i++) begin
            frag_valid = 1; frag_byte = base + 8'(i);
            while (!frag_ready) @(negedge clk);
            acc.push_back(frag_byte);
            @(negedge clk);
        end
        frag_valid = 0;
        if (len > 0) chk(frag_ready == 0, "R3 extra bytes accepted", frag_ready, 0);
        if (eof) begin
            for (int i = 0; i < acc.size(); i++) dat_q.push_back({i == acc.size() - 1, acc[i]});
            acc.delete();
            tb_open = 0;
        end
    endtask

    task automatic drain();
        int n = 0;
        while ((ctl_q.size() != 0 || dat_q.size() != 0) && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
        chk(ctl_q.size() == 0 && dat_q.size() == 0, "R4 scoreboard drained",
            ctl_q.size() + dat_q.size(), 0);
    endtask

    task automatic rx_rec(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rxc_tvalid = 1; rxc_tdata = base + 32'(i); rxc_tlast = (i == n - 1);
        end
        @(negedge clk);
        rxc_tvalid = 0; rxc_tlast = 0;
    endtask

    task automatic rx_frame(int beats);
        for (int i = 0; i < beats; i++) begin
            @(negedge clk);
            rxd_tvalid = 1; rxd_tlast = (i == beats - 1);
        end
        @(negedge clk);
        rxd_tvalid = 0; rxd_tlast = 0;
    endtask

    function automatic logic [159:0] mkrec(logic [31:0] b);
        logic [159:0] r;
        for (int k = 0; k < 5; k++) r[32*k +: 32] = b + 32'(k);
        return r;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(desc_ready == 1, "R1 desc_ready", desc_ready, 1);
        chk({ctl_tvalid, dat_tvalid, tx_err} == 0, "R1 tx outputs idle",
            {ctl_tvalid, dat_tvalid, tx_err}, 0);
        chk({cmp_valid, cmp_eof, rx_err} == 0, "R1 rx outputs idle",
            {cmp_valid, cmp_eof, rx_err}, 0);

        // single-fragment packet
        send(1, 1, 6, 32'h1000_0000, 8'h10);
        drain();

        // three fragments, middle one without start marker (R8)
        send(1, 0, 3, 32'h2000_0000, 8'h20);
        send(0, 0, 4, 32'hDEAD_0000, 8'h30);
        repeat (6) @(negedge clk);
        chk(dat_tvalid == 0, "R4 no data before end fragment", dat_tvalid, 0);
        send(0, 1, 2, 32'hBEEF_0000, 8'h40);
        drain();

        // backpressure on both outputs (R6)
        bp_en = 1;
        send(1, 0, 5, 32'h3000_0000, 8'h50);
        send(0, 0, 0, 32'h0, 8'h00);
        send(0, 1, 7, 32'h0, 8'h60);
        send(1, 1, 9, 32'h4000_0000, 8'h70);
        drain();

        // abort of open frame (R7)
        send(1, 0, 4, 32'h5000_0000, 8'h80);
        send(1, 1, 3, 32'h6000_0000, 8'h90);
        drain();
        chk(seen_err == exp_err && exp_err == 1, "R7 abort error pulses", seen_err, exp_err);

        // zero-length closing fragment and empty frame (R9)
        send(1, 0, 2, 32'h7000_0000, 8'hA0);
        send(0, 1, 0, 32'h0, 8'h00);
        send(1, 1, 0, 32'h8000_0000, 8'h00);
        drain();
        bp_en = 0;
        chk(seen_err == exp_err, "R7 no spurious error", seen_err, exp_err);

        // receive side
        rx_rec(5, 32'hA000_0000);
        chk(rx_err == 0, "R11 good record no error", rx_err, 0);
        rx_frame(3);
        chk(cmp_valid == 1, "R10 completion pulse", cmp_valid, 1);
        chk(cmp_rec == mkrec(32'hA000_0000), "R10 released record", cmp_rec, mkrec(32'hA000_0000));
        chk(cmp_eof == 1, "R10 eof status set", cmp_eof, 1);
        @(negedge clk);
        chk(cmp_valid == 0, "R10 pulse is one cycle", cmp_valid, 0);
        rxd_tvalid = 1; rxd_tlast = 0;
        @(negedge clk);
        rxd_tvalid = 0;
        chk(cmp_eof == 0, "R10 eof cleared by next frame", cmp_eof, 1'b0);

        rx_rec(4, 32'hB000_0000);
        chk(rx_err == 1, "R11 short record error", rx_err, 1);
        @(negedge clk);
        chk(rx_err == 0, "R11 error pulse one cycle", rx_err, 0);
        rx_frame(1);
        chk(cmp_rec == mkrec(32'hA000_0000), "R11 short record ignored", cmp_rec, mkrec(32'hA000_0000));
        rx_rec(6, 32'hC000_0000);
        chk(rx_err == 1, "R11 long record error", rx_err, 1);
        rx_frame(2);
        chk(cmp_rec == mkrec(32'hA000_0000), "R11 long record ignored", cmp_rec, mkrec(32'hA000_0000));
        rx_rec(5, 32'hD000_0000);
        rx_frame(1);
        chk(cmp_valid && cmp_rec == mkrec(32'hD000_0000), "R10 new record released",
            cmp_rec, mkrec(32'hD000_0000));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule